// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the storage side of a host bridge's control and status registers. Software reaches it through a word-wide register bus: a byte address, write data, a write strobe, a read strobe and a registered read-data return. The window holds twenty-eight 32-bit words. The word index is the byte address shifted right by two, and the two lowest address bits play no part in the decode. The hardware these registers steer (memory timing, PCI window mapping, GPIO, cache) sits outside the block. Only the stored values and the side effects of writes are built here.

Two registers have side effects. The interrupt-enable word cannot be written directly. It changes only through a set alias, which ORs the written data into it, and a clear alias, which removes the written ones from it. Each alias also keeps the last value written to it. In the general configuration word, a write that raises bit 2 from 0 to 1 sends a single-cycle system-reset request to the chip's reset logic.

The bus has no back-pressure. Every strobe is accepted in the cycle it is presented. Read data comes back on the next clock and holds until the next read.

Top module: `hbr_regfile`

## Requirements
- R1: After reset, words read back as follows: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000, and every other offset below 0x70 reads 0. Read data is 0 and the reset request is low.
- R2: A write to an ordinary word (any offset below 0x70 other than 0x30, 0x34, 0x38 and 0x3C) stores all 32 bits. A read strobe returns the word in the following cycle, and the read data holds its value until the next read strobe.
- R3: A write to 0x30 stores the data at 0x30 and ORs it into the enable word at 0x38.
- R4: A write to 0x34 stores the data at 0x34 and clears each bit of the enable word at 0x38 that is 1 in the data.
- R5: Writes to 0x38 (enable) and 0x3C (interrupt status) change nothing. The status word stays at its reset value of 0.
- R6: A write to 0x04 whose data has bit 2 set, while the stored bit 2 is 0, drives the reset request high for exactly the one cycle after the write edge. No other write raises it.
- R7: Writes to offsets 0x70 through 0xFC change no register, and reads of those offsets return 0.
- R8: Address bits [1:0] are ignored, so any byte address inside a word reaches that word.
- R9: A read and a write to the same word in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wen | input | 1 | Write strobe, one word per cycle |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the read strobe |
| sys_rst_req | output | 1 | Single-cycle system-reset request |

## Verification
Every result appears one clock after the edge that takes its strobe. Read data and the reset request are both registered once, and a stored word is visible to a read issued in the cycle after its write. The bench drives each strobe for one cycle from the falling edge and samples at the next falling edge. That is exactly one rising edge later, the cycle in which read data and any reset pulse are due. A reset pulse is checked again one falling edge further on, to show that it has dropped. A monitor counts pulses on every falling edge, so a pulse raised by the wrong write is also caught during the sweeps.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int DATA_W      = 32;
  localparam int NUM_REGS    = 28;
  localparam int IDX_PWRON   = 0;
  localparam int IDX_GEN     = 1;
  localparam int IDX_IODEV   = 2;
  localparam int IDX_SDRAM   = 3;
  localparam int IDX_MAP     = 4;
  localparam int IDX_GPIO_D  = 7;
  localparam int IDX_GPIO_IE = 8;
  localparam int IDX_EN_SET  = 12;
  localparam int IDX_EN_CLR  = 13;
  localparam int IDX_EN      = 14;
  localparam int IDX_STAT    = 15;
  localparam int IDX_DQ      = 26;
  localparam int IDX_MSIZE   = 27;
  localparam int ARM_BIT     = 2;

  function automatic logic [DATA_W-1:0] reset_value(input int idx);
    case (idx)
      IDX_PWRON:   return 32'h0000_0C40;
      IDX_GEN:     return 32'h0000_1384;
      IDX_IODEV:   return 32'h2BFF_8010;
      IDX_SDRAM:   return 32'h255E_0091;
      IDX_MAP:     return 32'h0000_6140;
      IDX_GPIO_D:  return 32'h0000_01FF;
      IDX_GPIO_IE: return 32'h0000_01FF;
      IDX_DQ:      return 32'h0000_0008;
      IDX_MSIZE:   return 32'h1000_0000;
      default:     return '0;
    endcase
  endfunction
endpackage

// File: rtl/hbr_addr_dec.sv
module hbr_addr_dec #(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_window
);
  import hbr_pkg::*;
  logic [ADDR_W-1:0] shifted;
  always_comb begin
    shifted   = addr >> 2;
    idx       = shifted[IDX_W-1:0];
    in_window = ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));
  end
endmodule

// File: rtl/hbr_enable_ctl.sv
module hbr_enable_ctl
  import hbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (set_we) en_q <= en_q | wdata;
    else if (clr_we) en_q <= en_q & ~wdata;
  end

  // R3
  en_set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> en_q == ($past(en_q) | $past(wdata)));
  // R4
  en_clr_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> en_q == ($past(en_q) & ~$past(wdata)));
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en_q));
endmodule

// File: rtl/hbr_reset_arm.sv
module hbr_reset_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_we,
  input  logic wr_bit,
  input  logic stored_bit,
  output logic req
);
  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= gen_we && wr_bit && !stored_bit;
  end

  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R6
  req_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> stored_bit && !$past(stored_bit));
endmodule

// File: rtl/hbr_regbank.sv
module hbr_regbank #(
  parameter int IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [hbr_pkg::DATA_W-1:0] wdata,
  input  logic [hbr_pkg::DATA_W-1:0] en_value,
  output logic [hbr_pkg::DATA_W-1:0] regs_q [hbr_pkg::NUM_REGS]
);
  import hbr_pkg::*;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (i == IDX_EN) begin : g_en
      assign regs_q[i] = en_value;
    end else if (i == IDX_STAT) begin : g_stat
      always_ff @(posedge clk) begin
        if (!rst_n) regs_q[i] <= reset_value(i);
      end
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)                              regs_q[i] <= reset_value(i);
        else if (wr_en && wr_idx == IDX_W'(i))   regs_q[i] <= wdata;
      end
    end
  end

  // R5
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(IDX_STAT)) |=> regs_q[IDX_STAT] == '0);
  // R2
  gen_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(IDX_GEN)) |=> regs_q[IDX_GEN] == $past(wdata));
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile #(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [hbr_pkg::DATA_W-1:0] bus_wdata,
  input  logic                       bus_wen,
  input  logic                       bus_ren,
  output logic [hbr_pkg::DATA_W-1:0] bus_rdata,
  output logic                       sys_rst_req
);
  import hbr_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              in_win;
  logic              wr_ok;
  logic [DATA_W-1:0] en_value;
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] rd_word;

  hbr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .idx(idx), .in_window(in_win)
  );

  assign wr_ok = bus_wen && in_win;

  hbr_enable_ctl u_en (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_ok && idx == IDX_W'(IDX_EN_SET)),
    .clr_we(wr_ok && idx == IDX_W'(IDX_EN_CLR)),
    .wdata(bus_wdata), .en_q(en_value)
  );

  hbr_regbank #(.IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_idx(idx),
    .wdata(bus_wdata), .en_value(en_value), .regs_q(regs_q)
  );

  hbr_reset_arm u_arm (
    .clk(clk), .rst_n(rst_n),
    .gen_we(wr_ok && idx == IDX_W'(IDX_GEN)),
    .wr_bit(bus_wdata[ARM_BIT]),
    .stored_bit(regs_q[IDX_GEN][ARM_BIT]),
    .req(sys_rst_req)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rd_word = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_word;
  end

  // R7
  out_of_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && !in_win) |=> bus_rdata == '0);
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |=> $stable(bus_rdata));
endmodule

// File: tb/tb_hbr_regfile.sv
module tb_hbr_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wen = 1'b0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int exp_pulses = 0;
  bit done = 1'b0;
  logic [31:0] m [28];

  always #(CLK_PERIOD/2) clk = ~clk;

  hbr_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wen(bus_wen), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req)
  );

  always @(negedge clk) if (rst_n && sys_rst_req) pulses++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_rd(input int w);
    return (w < 28) ? m[w] : 32'h0;
  endfunction

  function automatic void model_wr(input int w, input logic [31:0] d);
    if (w >= 28) return;
    case (w)
      12: begin m[12] = d; m[14] = m[14] | d; end
      13: begin m[13] = d; m[14] = m[14] & ~d; end
      14, 15: ;
      1: begin
        if (d[2] && !m[1][2]) exp_pulses++;
        m[1] = d;
      end
      default: m[w] = d;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk); bus_wen = 1'b0;
    model_wr(int'(a >> 2), d);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    @(negedge clk); bus_addr = a; bus_ren = 1'b1;
    @(negedge clk); bus_ren = 1'b0;
    chk(bus_rdata, expect_rd(int'(a >> 2)), tag);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    for (int i = 0; i < 28; i++) m[i] = 32'h0;
    m[0] = 32'h0000_0C40; m[1] = 32'h0000_1384; m[2] = 32'h2BFF_8010;
    m[3] = 32'h255E_0091; m[4] = 32'h0000_6140; m[7] = 32'h0000_01FF;
    m[8] = 32'h0000_01FF; m[26] = 32'h0000_0008; m[27] = 32'h1000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs idle after reset
    chk(bus_rdata, 32'h0, "R1 rdata after reset");
    chk({31'h0, sys_rst_req}, 32'h0, "R1 reset request idle");
    for (int w = 0; w < 64; w++) rd_chk(8'(w << 2), (w < 28) ? "R1 default" : "R7 outside read");

    // R2 R3 R4 R5 R7 R8: sweeps over every word with varied low address bits
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 64; w++) begin
        logic [31:0] d;
        d = (k == 2) ? 32'h0 : (k == 3) ? 32'hFFFF_FFFF
            : (32'h9E37_79B9 * 32'(w + 1)) ^ (32'h5A5A_5A5A * 32'(k + 1));
        wr(8'((w << 2) | k), d);
      end
      for (int w = 0; w < 64; w++) rd_chk(8'((w << 2) | (3 - k)), "R2 R3 R4 R5 R7 R8 sweep");
    end
    chk(32'(pulses), 32'(exp_pulses), "R6 pulse count over sweeps");

    // R3 R4: directed enable set and clear
    wr(8'h34, 32'hFFFF_FFFF);
    rd_chk(8'h38, "R4 enable cleared");
    wr(8'h30, 32'h0000_00F0);
    wr(8'h30, 32'h0000_0F00);
    rd_chk(8'h38, "R3 enable ORed");
    rd_chk(8'h30, "R3 set alias stored");
    wr(8'h34, 32'h0000_0110);
    rd_chk(8'h38, "R4 enable partial clear");
    chk(m[14], 32'h0000_0EE0, "R4 model sanity");
    wr(8'h38, 32'h1234_5678);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk(8'h38, "R5 enable write ignored");
    rd_chk(8'h3C, "R5 status write ignored");

    // R6: directed arm sequence
    wr(8'h04, 32'h0);
    chk({31'h0, sys_rst_req}, 32'h0, "R6 no pulse on clear");
    @(negedge clk); bus_addr = 8'h04; bus_wdata = 32'h4; bus_wen = 1'b1;
    @(negedge clk); bus_wen = 1'b0; model_wr(1, 32'h4);
    chk({31'h0, sys_rst_req}, 32'h1, "R6 pulse after arming write");
    @(negedge clk);
    chk({31'h0, sys_rst_req}, 32'h0, "R6 pulse lasts one cycle");
    wr(8'h04, 32'hFFFF_FFFF);
    chk({31'h0, sys_rst_req}, 32'h0, "R6 no pulse when already set");
    chk(32'(pulses), 32'(exp_pulses), "R6 pulse count");

    // R9: simultaneous read and write
    wr(8'h50, 32'hCAFE_0001);
    old = m[20];
    @(negedge clk); bus_addr = 8'h50; bus_wdata = 32'hBEEF_0002; bus_wen = 1'b1; bus_ren = 1'b1;
    @(negedge clk); bus_wen = 1'b0; bus_ren = 1'b0; model_wr(20, 32'hBEEF_0002);
    chk(bus_rdata, old, "R9 read returns pre-write value");
    rd_chk(8'h50, "R9 new value after");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule